// File: doc/BRIEF.md
# Calendar Time Registers with Deferred Commit

This block keeps wall-clock time and calendar date in two bus-visible words. A one-second strobe advances seconds, minutes and hours. A carry out of the last second of the day moves the date forward, using the month length and a leap marker that software supplies. The date register holds the day, the month and a six-bit year count that starts at 1970, so it covers 1970 through 2033.

Bus writes to either word do not take effect at once. They model a hand-over into a slow clock domain. An accepted write raises that word's busy flag in the control word and parks the value. The value is copied into the live register on the tick that ends a fixed number of seconds (`COMMIT_TICKS`), and the flag drops on that same tick. While any flag is raised the calendar does not advance. Software polls the flags before it writes, and it reads both words twice to get a coherent snapshot.

Top module: `rtc_cal_regs`

## Requirements
- R1: After reset the time word reads 00:00:00, the date word reads day 1, month 1, year 0 with the leap bit 0 (value 0x00000101), and the control word reads 0.
- R2: Read offsets are 0x00 for control, 0x10 for date and 0x14 for time. Any other offset reads 0. Time layout: seconds [5:0], minutes [13:8], hours [20:16]. Date layout: day [4:0], month [11:8], year [21:16], leap [22]. Control: bit 8 is time busy and bit 7 is date busy. All other bits read 0.
- R3: A write to the time or date offset while that word's flag is clear sets the flag from the next cycle. The live word keeps its old value.
- R4: The flag clears on the `COMMIT_TICKS`-th tick after the write. The written value appears in the live word on that same tick, and that tick does not advance it.
- R5: A write to a word whose busy flag is set is ignored. The value committed is the first one.
- R6: While either flag is set, ticks advance neither time nor date.
- R7: Seconds roll over 59 to 0, minutes roll over 59 to 0 and hours roll over 23 to 0, each carrying into the next field.
- R8: A carry out of 23:59:59 advances the day. The last day is 30 for months 4, 6, 9 and 11, 31 for the other months, and for month 2 it is 28, or 29 when the leap bit is set. After the last day the date goes to day 1 of the next month. The leap bit itself is never changed by counting.
- R9: Rolling past month 12 sets month 1 and increments the year, and year 63 wraps to 0.
- R10: Neither live word changes in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |

## Verification
The bench builds the block with `COMMIT_TICKS` set to 3. This keeps each commit short, so every month-end case can be set up and committed in a few ticks. It also leaves room for a full 86,400-second sweep with the tick held high. That sweep compares every second of the day with an arithmetic quotient-and-remainder model. Each month's last day is loaded with both leap settings at year 63, which also exercises the year wrap. The short commit window makes the frozen-counter and ignored-write cases cheap to probe tick by tick.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam logic [7:0]  OFS_CTRL      = 8'h00;
  localparam logic [7:0]  OFS_DATE      = 8'h10;
  localparam logic [7:0]  OFS_TIME      = 8'h14;
  localparam int unsigned BUSY_DATE_BIT = 7;
  localparam int unsigned BUSY_TIME_BIT = 8;
  localparam int unsigned N_SLOTS       = 2;
  localparam int unsigned SLOT_TIME     = 0;
  localparam int unsigned SLOT_DATE     = 1;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } hms_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] year;
    logic [3:0] mon;
    logic [4:0] day;
  } ymd_t;

  function automatic logic [WORD_W-1:0] hms_pack(hms_t t);
    return {11'd0, t.hr, 2'd0, t.min, 2'd0, t.sec};
  endfunction

  function automatic hms_t hms_unpack(logic [WORD_W-1:0] w);
    hms_t t;
    t.hr  = w[20:16];
    t.min = w[13:8];
    t.sec = w[5:0];
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] ymd_pack(ymd_t d);
    return {9'd0, d.leap, d.year, 4'd0, d.mon, 3'd0, d.day};
  endfunction

  function automatic ymd_t ymd_unpack(logic [WORD_W-1:0] w);
    ymd_t d;
    d.leap = w[22];
    d.year = w[21:16];
    d.mon  = w[11:8];
    d.day  = w[4:0];
    return d;
  endfunction

  function automatic logic [4:0] month_days(logic [3:0] mon, logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_commit_slot.sv
`timescale 1ns/1ps
module rtc_commit_slot #(
  parameter int unsigned WIDTH        = 32,
  parameter int unsigned COMMIT_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             load_o,
  output logic [WIDTH-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(COMMIT_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [WIDTH-1:0] hold_q;

  // write takes priority; a tick in the accept cycle is not counted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (wr_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(COMMIT_TICKS);
      hold_q <= wdata_i;
    end else if (busy_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign load_o = busy_q && tick_i && (cnt_q == CNT_W'(1)) && !wr_i
                  || busy_q && tick_i && (cnt_q == CNT_W'(1)) && wr_i;
  assign data_o = hold_q;
endmodule

// File: rtl/rtc_hms_ctr.sv
`timescale 1ns/1ps
module rtc_hms_ctr
  import rtc_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  hms_t load_val_i,
  input  logic step_i,
  output hms_t hms_o,
  output logic carry_o
);
  hms_t q;
  logic sec_end, min_end, hr_end;

  assign sec_end = (q.sec >= 6'd59);
  assign min_end = (q.min >= 6'd59);
  assign hr_end  = (q.hr  >= 5'd23);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (load_i) begin
      q <= load_val_i;
    end else if (step_i) begin
      if (!sec_end) begin
        q.sec <= q.sec + 6'd1;
      end else begin
        q.sec <= '0;
        if (!min_end) begin
          q.min <= q.min + 6'd1;
        end else begin
          q.min <= '0;
          q.hr  <= hr_end ? 5'd0 : q.hr + 5'd1;
        end
      end
    end
  end

  assign hms_o   = q;
  assign carry_o = step_i && !load_i && sec_end && min_end && hr_end;
endmodule

// File: rtl/rtc_ymd_ctr.sv
`timescale 1ns/1ps
module rtc_ymd_ctr
  import rtc_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  ymd_t load_val_i,
  input  logic step_i,
  output ymd_t ymd_o
);
  ymd_t       q;
  logic [4:0] last_day;

  assign last_day = month_days(q.mon, q.leap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      q.mon  <= 4'd1;
      q.day  <= 5'd1;
    end else if (load_i) begin
      q <= load_val_i;
    end else if (step_i) begin
      if (q.day < last_day) begin
        q.day <= q.day + 5'd1;
      end else begin
        q.day <= 5'd1;
        if (q.mon >= 4'd12) begin
          q.mon  <= 4'd1;
          q.year <= q.year + 6'd1;
        end else begin
          q.mon <= q.mon + 4'd1;
        end
      end
    end
  end

  assign ymd_o = q;
endmodule

// File: rtl/rtc_cal_regs.sv
`timescale 1ns/1ps
module rtc_cal_regs
  import rtc_cal_pkg::*;
#(
  parameter int unsigned COMMIT_TICKS = 4,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [N_SLOTS-1:0]              slot_hit;
  logic [N_SLOTS-1:0]              slot_busy;
  logic [N_SLOTS-1:0]              slot_load;
  logic [N_SLOTS-1:0][WORD_W-1:0]  slot_data;

  logic              busy_time, busy_date, frozen, day_carry;
  hms_t              hms;
  ymd_t              ymd;
  logic [WORD_W-1:0] time_word, date_word, ctrl_word;

  assign slot_hit[SLOT_TIME] = wr_en_i && (wr_addr_i == ADDR_W'(OFS_TIME));
  assign slot_hit[SLOT_DATE] = wr_en_i && (wr_addr_i == ADDR_W'(OFS_DATE));

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    rtc_commit_slot #(
      .WIDTH       (WORD_W),
      .COMMIT_TICKS(COMMIT_TICKS)
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (slot_hit[g]),
      .wdata_i(wr_data_i),
      .tick_i (tick_i),
      .busy_o (slot_busy[g]),
      .load_o (slot_load[g]),
      .data_o (slot_data[g])
    );
  end

  assign busy_time = slot_busy[SLOT_TIME];
  assign busy_date = slot_busy[SLOT_DATE];
  assign frozen    = |slot_busy;

  rtc_hms_ctr u_hms (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (slot_load[SLOT_TIME]),
    .load_val_i(hms_unpack(slot_data[SLOT_TIME])),
    .step_i    (tick_i && !frozen),
    .hms_o     (hms),
    .carry_o   (day_carry)
  );

  rtc_ymd_ctr u_ymd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (slot_load[SLOT_DATE]),
    .load_val_i(ymd_unpack(slot_data[SLOT_DATE])),
    .step_i    (day_carry),
    .ymd_o     (ymd)
  );

  assign time_word = hms_pack(hms);
  assign date_word = ymd_pack(ymd);

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[BUSY_TIME_BIT] = busy_time;
    ctrl_word[BUSY_DATE_BIT] = busy_date;
  end

  always_comb begin
    if (rd_addr_i == ADDR_W'(OFS_CTRL))      rd_data_o = ctrl_word;
    else if (rd_addr_i == ADDR_W'(OFS_DATE)) rd_data_o = date_word;
    else if (rd_addr_i == ADDR_W'(OFS_TIME)) rd_data_o = time_word;
    else                                     rd_data_o = '0;
  end
endmodule

// File: rtl/rtc_cal_regs_chk.sv
`timescale 1ns/1ps
module rtc_cal_regs_chk
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              busy_time,
  input logic              busy_date,
  input logic [WORD_W-1:0] time_word,
  input logic [WORD_W-1:0] date_word
);
  p_time_busy_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == ADDR_W'(OFS_TIME) && !busy_time |=> busy_time);

  p_date_busy_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == ADDR_W'(OFS_DATE) && !busy_date |=> busy_date);

  p_time_clear_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_time) |-> $past(tick_i));

  p_date_clear_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_date) |-> $past(tick_i));

  p_frozen_by_date_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && busy_date && !busy_time |=> $stable(time_word));

  p_time_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_word));

  p_date_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(date_word));
endmodule

bind rtc_cal_regs rtc_cal_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .busy_time(busy_time),
  .busy_date(busy_date),
  .time_word(time_word),
  .date_word(date_word)
);

// File: tb/rtc_cal_regs_test.sv
`timescale 1ns/1ps
module rtc_cal_regs_test;
  localparam int unsigned CT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  raddr = '0;
  logic [31:0] rdata;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rtc_cal_regs #(.COMMIT_TICKS(CT), .ADDR_W(8)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .wr_en_i  (we),
    .wr_addr_i(waddr),
    .wr_data_i(wdata),
    .rd_addr_i(raddr),
    .rd_data_o(rdata)
  );

  function automatic logic [31:0] tw(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] dw(int lp, int y, int m, int d);
    return (32'(lp) << 22) | (32'(y) << 16) | (32'(m) << 8) | 32'(d);
  endfunction

  function automatic int days_in(int m, int lp);
    if (m == 2) return 28 + lp;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    raddr = a;
    #1 d = rdata;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h14, v); check("R1 time", v, tw(0, 0, 0));
    rd(8'h10, v); check("R1 date", v, dw(0, 0, 1, 1));
    // R2 unmapped offset
    rd(8'h04, v); check("R2 unmapped", v, 32'h0);

    // R3 write sets time busy, live value unchanged
    wr(8'h14, tw(12, 34, 56));
    rd(8'h00, v); check("R3 time busy bit8", v, 32'h100);
    rd(8'h14, v); check("R3 time not yet live", v, tw(0, 0, 0));
    // R5 second write while busy ignored
    wr(8'h14, tw(1, 2, 3));
    // R6 frozen during commit
    ticks(CT - 1);
    rd(8'h14, v); check("R6 frozen time", v, tw(0, 0, 0));
    rd(8'h10, v); check("R6 frozen date", v, dw(0, 0, 1, 1));
    rd(8'h00, v); check("R4 still busy", v, 32'h100);
    tick1();
    rd(8'h00, v); check("R4 busy cleared", v, 32'h0);
    rd(8'h14, v); check("R5 first value committed", v, tw(12, 34, 56));
    tick1();
    rd(8'h14, v); check("R7 step", v, tw(12, 34, 57));

    // R6 date commit freezes time
    wr(8'h10, dw(0, 0, 1, 1));
    rd(8'h00, v); check("R3 date busy bit7", v, 32'h80);
    ticks(CT);
    rd(8'h14, v); check("R6 time frozen by date", v, tw(12, 34, 57));
    rd(8'h00, v); check("R4 date busy cleared", v, 32'h0);
    tick1();
    rd(8'h14, v); check("R7 resume", v, tw(12, 34, 58));
    // R10 no change without tick
    repeat (5) @(negedge clk);
    rd(8'h14, v); check("R10 idle time", v, tw(12, 34, 58));
    rd(8'h10, v); check("R10 idle date", v, dw(0, 0, 1, 1));

    // R7 full-day sweep, tick held high
    wr(8'h14, tw(0, 0, 0));
    ticks(CT);
    @(negedge clk);
    raddr = 8'h14;
    tick = 1'b1;
    for (int i = 1; i <= 86400; i++) begin
      @(negedge clk);
      #1;
      if (i == 86400) tick = 1'b0;
      check("R7 sweep", rdata, tw((i % 86400) / 3600, (i / 60) % 60, i % 60));
    end
    rd(8'h10, v); check("R8 day after sweep", v, dw(0, 0, 1, 2));

    // R8/R9 month ends, both leap settings, year 63
    for (int lp = 0; lp < 2; lp++) begin
      for (int m = 1; m <= 12; m++) begin
        wr(8'h10, dw(lp, 63, m, days_in(m, lp)));
        wr(8'h14, tw(23, 59, 59));
        ticks(CT);
        rd(8'h10, v); check("R4 date loaded", v, dw(lp, 63, m, days_in(m, lp)));
        tick1();
        rd(8'h14, v); check("R7 midnight", v, tw(0, 0, 0));
        rd(8'h10, v);
        if (m == 12) check("R9 year wrap", v, dw(lp, 0, 1, 1));
        else         check("R8 month end", v, dw(lp, 63, m + 1, 1));
      end
    end
    // R8 leap February 28 goes to 29
    wr(8'h10, dw(1, 10, 2, 28));
    wr(8'h14, tw(23, 59, 59));
    ticks(CT + 1);
    rd(8'h10, v); check("R8 leap feb 29", v, dw(1, 10, 2, 29));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule